// File: doc/BRIEF.md
# Belt Bulk Rename Map Unit

This unit keeps the mapping from logical belt slots to physical result registers for a belt of sixteen operand slots. The newest value always sits in slot 0. Two events change the map. A drop places a fresh physical register at slot 0 and moves every older slot back by one. The entry that was in the last slot is lost.

The second event is a branch that carries arguments. It renumbers the whole belt in one step. The values it names take slots 0, 1, 2 and upward, in the order they are listed. Every slot above the last listed value becomes invalid. The argument list arrives as a first op followed by any number of continuation ops. Each op carries up to three slot fields.

The unit gathers the fields in a staging buffer. It commits the new map on the cycle after the op flagged as last. The map therefore always shows the belt as it will be in the following cycle. A combinational lookup port lets decode translate a logical slot into its physical register.

Top module: `beltRenameMap`

## Requirements
- R1: After reset, all sixteen slots read as invalid on the lookup port.
- R2: A drop sampled at a clock edge puts `dropPhys` at slot 0 with valid set and moves slot k to slot k+1. The former content of slot 15 is discarded.
- R3: The lookup port is combinational. `lookupPhys` and `lookupValid` follow `lookupPos` within the same cycle, with no register in between.
- R4: A committed rename of N arguments (0 ≤ N ≤ 16) sets new slot k to the old contents (physical index and valid bit) of the slot named by argument k, for k < N. Every slot k ≥ N becomes invalid.
- R5: An op with `argFirst` high starts a new list. Any other op appends to the list in order. An op contributes fields 0 to `argCount`-1, and field i sits at `argPos[4*i +: 4]`. A list of N arguments is sent in ceil(N/3) ops, or in one op with `argCount` 0 when N is 0.
- R6: The map is unchanged in the cycle after the edge that samples the op with `argLast`. The renamed map appears after the next edge.
- R7: A slot may be named more than once in one list. Each occurrence yields a slot that points to the same physical register.
- R8: A list of more than 16 arguments raises `renameErr` during its commit cycle, and only then. The map is left unchanged.
- R9: When a drop and a rename commit at the same edge, the rename is applied first and the drop then shifts the renamed belt.
- R10: With no drop and no commit, the map holds. A list that has not yet received its last op does not change the map.
- R11: A rename with zero arguments leaves every slot invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dropValid | input | 1 | A new result is dropped on the belt this cycle |
| dropPhys | input | 6 | Physical register of the dropped result |
| argValid | input | 1 | An argument op is presented this cycle |
| argFirst | input | 1 | This op starts a new argument list |
| argLast | input | 1 | This op ends the argument list |
| argCount | input | 2 | Number of used fields in this op (0 to 3) |
| argPos | input | 12 | Three 4-bit logical slot fields; field i at bits 4*i+3:4*i |
| lookupPos | input | 4 | Logical slot to translate |
| lookupPhys | output | 6 | Physical register currently at `lookupPos` |
| lookupValid | output | 1 | Slot `lookupPos` holds a live value |
| renameErr | output | 1 | Commit cycle of an argument list longer than 16 |

## Verification
The hardest case to reach is a commit edge where everything moves at once. At that edge a full-length or repeated-slot list resolves against a belt that is also being shifted by a drop. In the same window a new list may already be starting. The stimulus first refills the belt with distinct physical indices, so every slot is traceable. It then sweeps every list length from 1 to 16 with a stride pattern that names slots out of order, half the time adding a drop in the commit cycle. The 10-entry list with duplicates, the empty list and the 17-entry list are driven as directed cases. The map is read through the lookup port in the commit cycle and again after it.

// File: rtl/beltPkg.sv
`timescale 1ns/1ps
package beltPkg;
  // Strobes from the argument collector to the map datapath.
  typedef struct packed {
    logic commit;  // apply the staged renumbering at this edge
    logic drop;    // push a new result at slot 0 at this edge
  } mapStrobe_t;
endpackage

// File: rtl/beltArgStage.sv
`timescale 1ns/1ps
module beltArgStage
  import beltPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int POS_W  = 4,
  parameter int FIELDS = 3,
  parameter int CNT_W  = 5,
  parameter int ARGC_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dropValid,
  input  logic                          argValid,
  input  logic                          argFirst,
  input  logic                          argLast,
  input  logic [ARGC_W-1:0]             argCount,
  input  logic [FIELDS*POS_W-1:0]       argPos,
  output mapStrobe_t                    strobe,
  output logic [DEPTH-1:0][POS_W-1:0]   stageList,
  output logic [CNT_W-1:0]              stageCount,
  output logic                          renameErr
);
  logic [CNT_W-1:0] fillCnt;
  logic             overflow;
  logic             pending;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] sumCnt;
  logic             nextOvf;
  logic [FIELDS-1:0][CNT_W-1:0] slotIdx;

  always_comb begin
    baseCnt = argFirst ? '0 : fillCnt;
    sumCnt  = baseCnt + CNT_W'(argCount);
    nextOvf = (argFirst ? 1'b0 : overflow) | (sumCnt > CNT_W'(DEPTH));
  end

  for (genvar i = 0; i < FIELDS; i++) begin : gSlot
    assign slotIdx[i] = baseCnt + CNT_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt   <= '0;
      overflow  <= 1'b0;
      pending   <= 1'b0;
      stageList <= '0;
    end else begin
      pending <= argValid && argLast;
      if (argValid) begin
        overflow <= nextOvf;
        fillCnt  <= (sumCnt > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : sumCnt;
        for (int i = 0; i < FIELDS; i++) begin
          if (ARGC_W'(i) < argCount && slotIdx[i] < CNT_W'(DEPTH))
            stageList[slotIdx[i][POS_W-1:0]] <= argPos[i*POS_W +: POS_W];
        end
      end
    end
  end

  assign strobe.commit = pending && !overflow;
  assign strobe.drop   = dropValid;
  assign stageCount    = fillCnt;
  assign renameErr     = pending && overflow;

  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit || renameErr) |-> $past(argValid && argLast)); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    renameErr |=> !renameErr || $past(argValid && argLast && argFirst)); // R8
endmodule

// File: rtl/beltMapPath.sv
`timescale 1ns/1ps
module beltMapPath
  import beltPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int POS_W  = 4,
  parameter int PHYS_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mapStrobe_t                    strobe,
  input  logic [DEPTH-1:0][POS_W-1:0]   stageList,
  input  logic [CNT_W-1:0]              stageCount,
  input  logic [PHYS_W-1:0]             dropPhys,
  input  logic [POS_W-1:0]              lookupPos,
  output logic [PHYS_W-1:0]             lookupPhys,
  output logic                          lookupValid
);
  logic [DEPTH-1:0][PHYS_W-1:0] mapPhys, renPhys, nxtPhys;
  logic [DEPTH-1:0]             mapValid, renValid, nxtValid;

  // Stage 1: bulk renumbering, all slots in parallel.
  always_comb begin
    renPhys  = mapPhys;
    renValid = mapValid;
    if (strobe.commit) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) < stageCount) begin
          renPhys[k]  = mapPhys[stageList[k]];
          renValid[k] = mapValid[stageList[k]];
        end else begin
          renValid[k] = 1'b0;
        end
      end
    end
  end

  // Stage 2: push-and-shift on top of the renamed belt.
  always_comb begin
    nxtPhys  = renPhys;
    nxtValid = renValid;
    if (strobe.drop) begin
      nxtPhys[0]  = dropPhys;
      nxtValid[0] = 1'b1;
      for (int k = 1; k < DEPTH; k++) begin
        nxtPhys[k]  = renPhys[k-1];
        nxtValid[k] = renValid[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapPhys  <= '0;
      mapValid <= '0;
    end else begin
      mapPhys  <= nxtPhys;
      mapValid <= nxtValid;
    end
  end

  assign lookupPhys  = mapPhys[lookupPos];
  assign lookupValid = mapValid[lookupPos];

  AST_DROP_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> mapValid[0] && mapPhys[0] == $past(dropPhys)); // R2
  AST_DROP_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drop && !strobe.commit) |=> mapPhys[DEPTH-1] == $past(mapPhys[DEPTH-2])
      && mapValid[DEPTH-1] == $past(mapValid[DEPTH-2])); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.drop && !strobe.commit) |=> $stable(mapPhys) && $stable(mapValid)); // R10
  AST_RENAME_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.drop && stageCount != '0) |=>
      mapPhys[0] == $past(mapPhys[stageList[0]])); // R4
  AST_RENAME_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.drop && stageCount < CNT_W'(DEPTH)) |=>
      !mapValid[DEPTH-1]); // R4
  AST_MERGE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.drop && stageCount != '0) |=>
      mapPhys[1] == $past(mapPhys[stageList[0]])); // R9
endmodule

// File: rtl/beltRenameMap.sv
`timescale 1ns/1ps
module beltRenameMap
  import beltPkg::*;
#(
  parameter int BELT_DEPTH  = 16,
  parameter int PHYS_W      = 6,
  parameter int ARGS_PER_OP = 3
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      dropValid,
  input  logic [PHYS_W-1:0]                         dropPhys,
  input  logic                                      argValid,
  input  logic                                      argFirst,
  input  logic                                      argLast,
  input  logic [$clog2(ARGS_PER_OP+1)-1:0]          argCount,
  input  logic [ARGS_PER_OP*$clog2(BELT_DEPTH)-1:0] argPos,
  input  logic [$clog2(BELT_DEPTH)-1:0]             lookupPos,
  output logic [PHYS_W-1:0]                         lookupPhys,
  output logic                                      lookupValid,
  output logic                                      renameErr
);
  localparam int POS_W  = $clog2(BELT_DEPTH);
  localparam int ARGC_W = $clog2(ARGS_PER_OP + 1);
  localparam int CNT_W  = $clog2(BELT_DEPTH + ARGS_PER_OP + 1);

  mapStrobe_t                       strobe;
  logic [BELT_DEPTH-1:0][POS_W-1:0] stageList;
  logic [CNT_W-1:0]                 stageCount;

  beltArgStage #(
    .DEPTH(BELT_DEPTH), .POS_W(POS_W), .FIELDS(ARGS_PER_OP),
    .CNT_W(CNT_W), .ARGC_W(ARGC_W)
  ) uStage (
    .clk(clk), .rstN(rstN), .dropValid(dropValid),
    .argValid(argValid), .argFirst(argFirst), .argLast(argLast),
    .argCount(argCount), .argPos(argPos),
    .strobe(strobe), .stageList(stageList), .stageCount(stageCount),
    .renameErr(renameErr)
  );

  beltMapPath #(
    .DEPTH(BELT_DEPTH), .POS_W(POS_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stageList(stageList), .stageCount(stageCount),
    .dropPhys(dropPhys), .lookupPos(lookupPos),
    .lookupPhys(lookupPhys), .lookupValid(lookupValid)
  );
endmodule

// File: tb/sim_beltRenameMap.sv
`timescale 1ns/1ps
module sim_beltRenameMap;
  logic        clk = 1'b0;
  logic        rstN;
  logic        dropValid;
  logic [5:0]  dropPhys;
  logic        argValid, argFirst, argLast;
  logic [1:0]  argCount;
  logic [11:0] argPos;
  logic [3:0]  lookupPos;
  logic [5:0]  lookupPhys;
  logic        lookupValid;
  logic        renameErr;

  int refPhys [16];
  bit refValid[16];
  int lst[24];
  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  beltRenameMap u0 (
    .clk(clk), .rstN(rstN), .dropValid(dropValid), .dropPhys(dropPhys),
    .argValid(argValid), .argFirst(argFirst), .argLast(argLast),
    .argCount(argCount), .argPos(argPos), .lookupPos(lookupPos),
    .lookupPhys(lookupPhys), .lookupValid(lookupValid), .renameErr(renameErr)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R3: lookup is read combinationally, position by position within one cycle.
  task automatic checkMap(string req);
    for (int p = 0; p < 16; p++) begin
      lookupPos = 4'(p);
      #0.1;
      chk(lookupValid === refValid[p], req, $sformatf("valid slot %0d", p),
          int'(lookupValid), int'(refValid[p]));
      if (refValid[p])
        chk(lookupPhys === 6'(refPhys[p]), req, $sformatf("phys slot %0d", p),
            int'(lookupPhys), refPhys[p]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic modelDrop(int v);
    for (int k = 15; k > 0; k--) begin
      refPhys[k]  = refPhys[k-1];
      refValid[k] = refValid[k-1];
    end
    refPhys[0]  = v;
    refValid[0] = 1'b1;
  endtask

  task automatic doDrop(int v);
    dropValid = 1'b1;
    dropPhys  = 6'(v);
    tick();
    dropValid = 1'b0;
    modelDrop(v);
  endtask

  task automatic refill(int base);
    for (int i = 0; i < 16; i++) doDrop((base + i) % 64);
  endtask

  // Sends lst[0..n-1] in ops of three; optional drop in the commit cycle.
  task automatic branch(int n, bit withDrop, int dv, string req);
    int chunks;
    int oldPhys [16];
    bit oldValid[16];
    chunks = (n == 0) ? 1 : (n + 2) / 3;
    for (int c = 0; c < chunks; c++) begin
      int cnt;
      cnt = n - 3 * c;
      if (cnt > 3) cnt = 3;
      argValid = 1'b1;
      argFirst = (c == 0);
      argLast  = (c == chunks - 1);
      argCount = 2'(cnt);
      argPos   = '0;
      for (int i = 0; i < 3; i++)
        if (i < cnt) argPos[4*i +: 4] = 4'(lst[3*c + i]);
      tick();
    end
    argValid = 1'b0;
    argFirst = 1'b0;
    argLast  = 1'b0;
    // Commit cycle: map still old (R6), error only for long lists (R8).
    checkMap("R6");
    chk(renameErr === (n > 16), "R8", "renameErr in commit cycle", int'(renameErr), int'(n > 16));
    if (withDrop) begin
      dropValid = 1'b1;
      dropPhys  = 6'(dv);
    end
    tick();
    dropValid = 1'b0;
    chk(renameErr === 1'b0, "R8", "renameErr after commit", int'(renameErr), 0);
    if (n <= 16) begin
      for (int k = 0; k < 16; k++) begin
        oldPhys[k] = refPhys[k];
        oldValid[k] = refValid[k];
      end
      for (int k = 0; k < 16; k++) begin
        if (k < n) begin
          refPhys[k]  = oldPhys[lst[k]];
          refValid[k] = oldValid[lst[k]];
        end else begin
          refValid[k] = 1'b0;
        end
      end
    end
    if (withDrop) modelDrop(dv);
    checkMap(req);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    nTests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; dropValid = 1'b0; dropPhys = '0;
    argValid = 1'b0; argFirst = 1'b0; argLast = 1'b0;
    argCount = '0; argPos = '0; lookupPos = '0;
    for (int k = 0; k < 16; k++) begin refPhys[k] = 0; refValid[k] = 1'b0; end
    tick(); tick();
    rstN = 1'b1;
    checkMap("R1");

    // R2: 20 drops, overflowing the belt; checked after each.
    for (int i = 0; i < 20; i++) begin
      doDrop(40 + i);
      checkMap("R2");
    end

    // R4 R5 R7: ten arguments with repeats, four ops (3,3,3,1).
    lst[0]=4; lst[1]=6; lst[2]=2; lst[3]=2; lst[4]=3;
    lst[5]=8; lst[6]=0; lst[7]=9; lst[8]=3; lst[9]=11;
    branch(10, 1'b0, 0, "R7");

    // R4 full-length reversed list.
    refill(1);
    for (int k = 0; k < 16; k++) lst[k] = 15 - k;
    branch(16, 1'b0, 0, "R4");

    // R11 empty list.
    refill(20);
    branch(0, 1'b0, 0, "R11");

    // R8 seventeen arguments: error, map kept.
    refill(30);
    for (int k = 0; k < 17; k++) lst[k] = k % 16;
    branch(17, 1'b0, 0, "R8");

    // R9 rename and drop at the same edge.
    for (int k = 0; k < 5; k++) lst[k] = (k * 3 + 1) % 16;
    branch(5, 1'b1, 63, "R9");

    // R10 list without its last op leaves the map alone.
    refill(5);
    argValid = 1'b1; argFirst = 1'b1; argLast = 1'b0;
    argCount = 2'd3; argPos = {4'd7, 4'd8, 4'd9};
    tick();
    argValid = 1'b0; argFirst = 1'b0;
    tick(); tick();
    checkMap("R10");
    chk(renameErr === 1'b0, "R10", "renameErr idle", int'(renameErr), 0);

    // R5 sweep over every length, with and without a merged drop (R9).
    for (int n = 1; n <= 16; n++) begin
      refill(n * 3);
      for (int k = 0; k < n; k++) lst[k] = (k * 5 + n) % 16;
      branch(n, (n % 2) == 0, 50 + n, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule